// File: doc/BRIEF.md
# Indexed Byte-Memory Access Port with Region Locks

This block gives a processor a four-byte I/O window onto a byte-wide memory. Software first loads a 16-bit address pointer one byte at a time. Offset 0 carries the low byte and offset 1 the high byte. It then reads or writes the addressed byte through offset 3. After every data write the pointer clears to zero. A data read leaves the pointer where it was, so repeated reads return the same location.

Behind the window sits an internal RAM whose size is a parameter. Two 16-byte regions near the bottom of memory can be made inaccessible by two lock bits, which a separate control input loads. When the clock area is enabled, the top 16 bytes of the address space are not RAM. Accesses there pass straight through to an external register port, with the low four pointer bits as the register index. All reads return their byte one cycle after the request, marked by a valid strobe.

Top module: `nvram_index_port`

## Requirements
- R1: A write to offset 0 replaces bits 7:0 of the address pointer, and a write to offset 1 replaces bits 15:8. The other half is kept.
- R2: A write to offset 3 stores the data byte at the pointer address. The pointer then becomes zero.
- R3: A read from offset 3 returns the byte at the pointer address and leaves the pointer unchanged.
- R4: A read from offset 0, 1 or 2 returns 0xFF. A write to offset 2 changes neither the pointer nor any memory byte.
- R5: While lock bit 0 is set, addresses 0x20 to 0x2F read as 0xFF and writes to them are dropped. The stored bytes come back once the lock is cleared.
- R6: Lock bit 1 does the same for addresses 0x30 to 0x3F.
- R7: A write to an address at or above MEM_BYTES is dropped, and a read there returns 0xFF.
- R8: With the clock area enabled, addresses MEM_BYTES-16 to MEM_BYTES-1 go to the external register port and not to RAM. A write there pulses the port write strobe with the byte. A read pulses the port read strobe and returns the port data. The port index is pointer bits 3:0.
- R9: io_rvalid is high in exactly the cycle after each read request (io_rd high with io_wr low). io_rdata holds the byte in that cycle. When io_rd and io_wr are both high, the write is performed and the read is ignored.
- R10: Reset clears the pointer and both lock bits. While lock_load is high, the lock bits take lock_value on the next clock (bit 0 for the lower region).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_wr | input | 1 | Window write request |
| io_rd | input | 1 | Window read request |
| io_off | input | 2 | Window offset |
| io_wdata | input | 8 | Window write byte |
| io_rdata | output | 8 | Read byte, valid with io_rvalid |
| io_rvalid | output | 1 | Read data valid, one cycle after the request |
| lock_load | input | 1 | Load enable for the lock bits |
| lock_value | input | 2 | New lock bits |
| clk_reg_wr | output | 1 | External register write strobe |
| clk_reg_rd | output | 1 | External register read strobe |
| clk_reg_addr | output | 4 | External register index |
| clk_reg_wdata | output | 8 | External register write byte |
| clk_reg_rdata | input | 8 | External register read byte, sampled in the strobe cycle |

## Verification
The bench writes and reads back every address from zero to twice the memory size. This catches any comparison that truncates the 16-bit pointer. A decoder that looked only at the low address bits would alias out-of-range addresses onto RAM and return stored bytes instead of 0xFF. Each lock combination is exercised with writes while locked and read-back after unlocking. A lock that blocked only reads would show the new pattern after unlock, and a lock that hit the wrong region would leave 0xFF where data is expected. Further checks read with no pointer reload after a data write, write to offset 2, and apply reset while the pointer and locks are set. A design that failed to clear, or that let the unused offset disturb the pointer, then returns the wrong location's byte.

// File: rtl/nvram_pkg.sv
package nvram_pkg;
  localparam int BYTE_W   = 8;
  localparam int PTR_W    = 16;
  localparam int LOCK_N   = 2;
  localparam int CLK_SPAN = 16;
  localparam int LOCK_BASE = 32;

  typedef enum logic [1:0] {
    SRC_ONES = 2'd0,
    SRC_RAM  = 2'd1,
    SRC_EXT  = 2'd2
  } rd_src_e;

  typedef enum logic [1:0] {
    OFF_PTR_LO = 2'd0,
    OFF_PTR_HI = 2'd1,
    OFF_SPARE  = 2'd2,
    OFF_DATA   = 2'd3
  } win_off_e;
endpackage

// File: rtl/nvram_rst_sync.sv
module nvram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/nvram_ptr_reg.sv
module nvram_ptr_reg
  import nvram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              clr,
  input  logic [BYTE_W-1:0] data,
  input  logic              lock_load,
  input  logic [LOCK_N-1:0] lock_value,
  output logic [PTR_W-1:0]  ptr,
  output logic [LOCK_N-1:0] locks
);
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              ptr_en;
  logic [LOCK_N-1:0] lock_q;

  always_comb begin
    ptr_d = ptr_q;
    if (clr)        ptr_d = '0;
    else if (ld_lo) ptr_d[BYTE_W-1:0] = data;
    else if (ld_hi) ptr_d[PTR_W-1:BYTE_W] = data;
  end

  assign ptr_en = clr | ld_lo | ld_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lock_q <= '0;
    else if (lock_load) lock_q <= lock_value;
  end

  assign ptr   = ptr_q;
  assign locks = lock_q;
endmodule

// File: rtl/nvram_addr_decode.sv
module nvram_addr_decode
  import nvram_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter bit CLK_AREA_EN = 1'b1,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic [PTR_W-1:0]  ptr,
  input  logic [LOCK_N-1:0] locks,
  output logic              ram_hit,
  output logic              ext_hit,
  output logic [AW-1:0]     ram_idx
);
  localparam int RAM_TOP = CLK_AREA_EN ? MEM_BYTES - CLK_SPAN : MEM_BYTES;
  localparam int HI_W    = PTR_W - 4;
  localparam logic [PTR_W-1:0] RAM_TOP_C = PTR_W'(RAM_TOP);
  localparam logic [PTR_W-1:0] MEM_TOP_C = PTR_W'(MEM_BYTES);

  logic [LOCK_N-1:0] lock_hit;

  for (genvar i = 0; i < LOCK_N; i++) begin : g_lock
    localparam logic [HI_W-1:0] REGION = HI_W'((LOCK_BASE + 16 * i) / 16);
    assign lock_hit[i] = locks[i] && (ptr[PTR_W-1:4] == REGION);
  end

  assign ram_hit = (ptr < RAM_TOP_C) && !(|lock_hit);

  if (CLK_AREA_EN) begin : g_ext
    assign ext_hit = (ptr >= RAM_TOP_C) && (ptr < MEM_TOP_C);
  end else begin : g_no_ext
    assign ext_hit = 1'b0;
  end

  assign ram_idx = ptr[AW-1:0];
endmodule

// File: rtl/nvram_byte_ram.sv
module nvram_byte_ram
  import nvram_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [BYTE_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
  import nvram_pkg::*;
#(
  parameter int MEM_BYTES   = 1024,
  parameter bit CLK_AREA_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic [1:0] io_off,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       io_rvalid,
  input  logic       lock_load,
  input  logic [1:0] lock_value,
  output logic       clk_reg_wr,
  output logic       clk_reg_rd,
  output logic [3:0] clk_reg_addr,
  output logic [7:0] clk_reg_wdata,
  input  logic [7:0] clk_reg_rdata
);
  localparam int AW = $clog2(MEM_BYTES);

  logic              rst_sync_n;
  logic [PTR_W-1:0]  ptr;
  logic [LOCK_N-1:0] locks;
  logic              ram_hit, ext_hit;
  logic [AW-1:0]     ram_idx;
  logic              rd_req, data_wr, data_rd;
  logic              ram_we, ram_re;
  logic [BYTE_W-1:0] ram_rdata;
  rd_src_e           src_q, src_d;
  logic [BYTE_W-1:0] ext_q;
  logic              rvalid_q;

  nvram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign rd_req  = io_rd && !io_wr;
  assign data_wr = io_wr && (io_off == OFF_DATA);
  assign data_rd = rd_req && (io_off == OFF_DATA);

  nvram_ptr_reg u_ptr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ld_lo      (io_wr && (io_off == OFF_PTR_LO)),
    .ld_hi      (io_wr && (io_off == OFF_PTR_HI)),
    .clr        (data_wr),
    .data       (io_wdata),
    .lock_load  (lock_load),
    .lock_value (lock_value),
    .ptr        (ptr),
    .locks      (locks)
  );

  nvram_addr_decode #(
    .MEM_BYTES   (MEM_BYTES),
    .CLK_AREA_EN (CLK_AREA_EN)
  ) u_dec (
    .ptr     (ptr),
    .locks   (locks),
    .ram_hit (ram_hit),
    .ext_hit (ext_hit),
    .ram_idx (ram_idx)
  );

  assign ram_we = data_wr && ram_hit;
  assign ram_re = data_rd && ram_hit;

  nvram_byte_ram #(
    .DEPTH (MEM_BYTES)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_idx),
    .wdata (io_wdata),
    .rdata (ram_rdata)
  );

  assign clk_reg_wr    = data_wr && ext_hit;
  assign clk_reg_rd    = data_rd && ext_hit;
  assign clk_reg_addr  = ptr[3:0];
  assign clk_reg_wdata = io_wdata;

  always_comb begin
    src_d = SRC_ONES;
    if (ram_re)          src_d = SRC_RAM;
    else if (clk_reg_rd) src_d = SRC_EXT;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  src_q <= SRC_ONES;
    else if (rd_req)  src_q <= src_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     ext_q <= '0;
    else if (clk_reg_rd) ext_q <= clk_reg_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rvalid_q <= 1'b0;
    else             rvalid_q <= rd_req;
  end

  always_comb begin
    case (src_q)
      SRC_RAM: io_rdata = ram_rdata;
      SRC_EXT: io_rdata = ext_q;
      default: io_rdata = 8'hFF;
    endcase
  end

  assign io_rvalid = rvalid_q;
endmodule

// File: rtl/nvram_index_port_chk.sv
module nvram_index_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic        io_rd,
  input logic [1:0]  io_off,
  input logic [7:0]  io_rdata,
  input logic        io_rvalid,
  input logic        clk_reg_wr,
  input logic        clk_reg_rd,
  input logic [15:0] ptr,
  input logic [1:0]  locks
);
  assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr) |=> io_rvalid);

  assert_rvalid_only_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && !io_wr) |=> !io_rvalid);

  assert_ptr_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_off == 2'd3) |=> (ptr == 16'h0000));

  assert_ptr_kept_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr) |=> $stable(ptr));

  assert_window_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_off != 2'd3) |=> (io_rdata == 8'hFF));

  assert_lock0_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_off == 2'd3 && locks[0] && ptr[15:4] == 12'h002)
      |=> (io_rdata == 8'hFF));

  assert_lock1_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_off == 2'd3 && locks[1] && ptr[15:4] == 12'h003)
      |=> (io_rdata == 8'hFF));

  assert_ext_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clk_reg_wr, clk_reg_rd}));

  assert_ext_wr_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_reg_wr |-> (io_wr && io_off == 2'd3));

  assert_ext_rd_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_reg_rd |-> (io_rd && !io_wr && io_off == 2'd3));
endmodule

bind nvram_index_port nvram_index_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_off     (io_off),
  .io_rdata   (io_rdata),
  .io_rvalid  (io_rvalid),
  .clk_reg_wr (clk_reg_wr),
  .clk_reg_rd (clk_reg_rd),
  .ptr        (ptr),
  .locks      (locks)
);

// File: tb/nvram_index_port_test.sv
module nvram_index_port_test;
  localparam int MB  = 256;
  localparam int EXT = MB - 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       io_wr, io_rd;
  logic [1:0] io_off;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  logic       io_rvalid;
  logic       lock_load;
  logic [1:0] lock_value;
  logic       clk_reg_wr, clk_reg_rd;
  logic [3:0] clk_reg_addr;
  logic [7:0] clk_reg_wdata;
  logic [7:0] clk_reg_rdata;

  logic [7:0] ext_regs [16];
  logic [7:0] exp_ram  [MB];
  logic [7:0] exp_ext  [16];
  logic [1:0] exp_locks;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  nvram_index_port #(.MEM_BYTES(MB), .CLK_AREA_EN(1'b1)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_wr         (io_wr),
    .io_rd         (io_rd),
    .io_off        (io_off),
    .io_wdata      (io_wdata),
    .io_rdata      (io_rdata),
    .io_rvalid     (io_rvalid),
    .lock_load     (lock_load),
    .lock_value    (lock_value),
    .clk_reg_wr    (clk_reg_wr),
    .clk_reg_rd    (clk_reg_rd),
    .clk_reg_addr  (clk_reg_addr),
    .clk_reg_wdata (clk_reg_wdata),
    .clk_reg_rdata (clk_reg_rdata)
  );

  always @(posedge clk) if (clk_reg_wr) ext_regs[clk_reg_addr] <= clk_reg_wdata;
  assign clk_reg_rdata = ext_regs[clk_reg_addr];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 37 + seed * 11 + (a >> 8) * 5) & 255);
  endfunction

  function automatic bit locked_at(input int a);
    return (exp_locks[0] && a >= 32 && a < 48) || (exp_locks[1] && a >= 48 && a < 64);
  endfunction

  function automatic logic [7:0] expect_at(input int a);
    if (a >= MB)       return 8'hFF;
    if (a >= EXT)      return exp_ext[a - EXT];
    if (locked_at(a))  return 8'hFF;
    return exp_ram[a];
  endfunction

  task automatic model_write(input int a, input logic [7:0] d);
    if (a < EXT && !locked_at(a)) exp_ram[a] = d;
    else if (a >= EXT && a < MB)  exp_ext[a - EXT] = d;
  endtask

  task automatic io_write(input logic [1:0] o, input logic [7:0] d);
    @(negedge clk);
    io_off = o; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [1:0] o, output logic [7:0] v, output logic vld);
    @(negedge clk);
    io_off = o; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    vld = io_rvalid;
    v   = io_rdata;
  endtask

  task automatic set_ptr(input int a);
    io_write(2'd0, 8'(a & 255));
    io_write(2'd1, 8'((a >> 8) & 255));
  endtask

  task automatic write_at(input int a, input logic [7:0] d);
    set_ptr(a);
    io_write(2'd3, d);
    model_write(a, d);
  endtask

  task automatic read_check(input int a, input string req);
    logic [7:0] v;
    logic vld;
    set_ptr(a);
    io_read(2'd3, v, vld);
    check(req, {7'd0, vld}, 8'd1);
    check(req, v, expect_at(a));
  endtask

  task automatic load_locks(input logic [1:0] l);
    @(negedge clk);
    lock_load = 1'b1; lock_value = l;
    @(negedge clk);
    lock_load = 1'b0;
    exp_locks = l;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin ext_regs[i] = 8'h00; exp_ext[i] = 8'h00; end
    io_wr = 1'b0; io_rd = 1'b0; io_off = 2'd0; io_wdata = 8'h00;
    lock_load = 1'b0; lock_value = 2'b00; exp_locks = 2'b00;
    do_reset();
  end

  initial begin
    logic [7:0] v, v2;
    logic vld;
    wait (rst_n === 1'b1);
    repeat (5) @(negedge clk);

    // R10: reset state of the read path
    check("R10 rvalid after reset", {7'd0, io_rvalid}, 8'd0);
    check("R10 rdata after reset", io_rdata, 8'hFF);

    // R1 R2 R7 R8: write sweep across RAM, external area and out-of-range addresses
    for (int a = 0; a < 2 * MB; a++) write_at(a, pat(a, 1));
    for (int a = 0; a < 2 * MB; a++) begin
      if (a >= MB)       read_check(a, "R7 out of range");
      else if (a >= EXT) read_check(a, "R8 external area");
      else               read_check(a, "R1 pointer halves");
    end

    // R8: the external register file itself holds the written bytes
    for (int i = 0; i < 16; i++) check("R8 port write", ext_regs[i], pat(EXT + i, 1));

    // R2: after a data write the pointer is zero
    write_at(8'h77, 8'h5A);
    io_read(2'd3, v, vld);
    check("R2 pointer cleared", v, expect_at(0));

    // R3 R9: repeated reads keep the pointer; valid only after a request
    set_ptr(16'h0045);
    io_read(2'd3, v, vld);
    io_read(2'd3, v2, vld);
    check("R3 first read", v, expect_at(16'h45));
    check("R3 second read", v2, expect_at(16'h45));
    @(negedge clk);
    check("R9 idle valid", {7'd0, io_rvalid}, 8'd0);

    // R9: simultaneous read and write performs only the write
    set_ptr(16'h0050);
    @(negedge clk);
    io_off = 2'd3; io_wdata = 8'hC3; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    model_write(16'h50, 8'hC3);
    check("R9 no valid on combined access", {7'd0, io_rvalid}, 8'd0);
    read_check(16'h50, "R9 combined access wrote");

    // R4: window offsets other than data read as ones; offset 2 write ignored
    set_ptr(16'h0012);
    for (int o = 0; o < 3; o++) begin
      io_read(2'(o), v, vld);
      check("R4 window ones", v, 8'hFF);
    end
    io_write(2'd2, 8'hAB);
    io_read(2'd3, v, vld);
    check("R4 spare write ignored", v, expect_at(16'h12));

    // R5 R6 R10: every lock combination, writes while locked, read-back after unlock
    for (int l = 1; l < 4; l++) begin
      load_locks(2'(l));
      for (int a = 32; a < 64; a++) write_at(a, pat(a, 2 + l));
      for (int a = 32; a < 64; a++) read_check(a, (a < 48) ? "R5 lower lock" : "R6 upper lock");
      load_locks(2'b00);
      for (int a = 32; a < 64; a++) read_check(a, (a < 48) ? "R5 after unlock" : "R6 after unlock");
    end

    // R10: reset clears the pointer and the locks
    load_locks(2'b11);
    set_ptr(16'h0025);
    do_reset();
    exp_locks = 2'b00;
    io_read(2'd3, v, vld);
    check("R10 pointer reset", v, expect_at(0));
    read_check(16'h25, "R10 locks reset");
    read_check(16'h35, "R10 locks reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule